// File: doc/BRIEF.md
# Shared Self-Test Control Register

This block is an 8-bit self-test control register that two agents share. A host agent asks for a self-test by writing the start bit. A local processor receives a level interrupt, runs the test in software, and then writes back a 4-bit completion code while clearing the start bit. Each agent has its own port, with a write strobe, a write byte and a read-back byte. Both ports read the same register image.

The capability flag in the top bit is not stored. It always shows an external enable that a separate configuration register supplies. The interrupt is the start bit gated by that enable. If the enable is low, a host request stays pending and raises nothing until the enable goes high. The register occupies byte offset 0x0F of the host configuration header. Address decoding is done outside the block, so each write strobe already means "this register".

Top module: `bist_ctl_reg`

## Requirements
- R1: A synchronous active-low reset clears the start bit (bit 6) and the completion code (bits 3:0), and it deasserts the interrupt.
- R2: Bit 7 reads back the current value of the enable input on both ports, and writes to bit 7 from either port have no effect.
- R3: Bits 5:4 read as zero on both ports, and writes to them from either port are ignored.
- R4: A host write with bit 6 = 1 sets the start bit. A host write with bit 6 = 0 leaves the start bit unchanged.
- R5: Host writes never change the completion code in bits 3:0.
- R6: A local write loads bits 3:0 from the write data. A local write with bit 6 = 0 clears the start bit, and one with bit 6 = 1 leaves it unchanged.
- R7: The interrupt output equals the start bit AND the enable input at all times. With the enable low, a set start bit stays set and no interrupt is raised.
- R8: When a host write with bit 6 = 1 and a local write with bit 6 = 0 occur in the same cycle, the start bit ends up set. The local code is still loaded.
- R9: A single local write that clears start and posts a nonzero code completes the handshake. On the next cycle the interrupt is low and the code reads back on both ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bist_en | input | 1 | Self-test interrupt enable from the configuration register |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read-back byte |
| loc_we | input | 1 | Local processor write strobe |
| loc_wdata | input | 8 | Local processor write byte |
| loc_rdata | output | 8 | Local processor read-back byte |
| loc_irq | output | 1 | Level interrupt to the local processor |

## Verification
The hardest case to reach is a collision on the start bit: a host set and a local clear must land on the same clock edge. The bench drives both strobes from one task in the same cycle. It then checks that the start bit survives and that the local code is still taken. A second awkward case is a request made while the enable is low. The bench sets start with the enable low, confirms that no interrupt appears, and then raises the enable to check that the pending request immediately produces the interrupt.

// File: rtl/bist_ctl_reg.sv
module bist_ctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bist_en,
  input  logic       host_we,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       loc_we,
  input  logic [7:0] loc_wdata,
  output logic [7:0] loc_rdata,
  output logic       loc_irq
);

  logic       start_q;
  logic [3:0] code_q;
  logic       host_set;
  logic       loc_clr;
  logic [7:0] image;

  assign host_set = host_we && host_wdata[6];
  assign loc_clr  = loc_we && !loc_wdata[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      code_q  <= 4'h0;
    end else begin
      if (host_set)
        start_q <= 1'b1;
      else if (loc_clr)
        start_q <= 1'b0;
      if (loc_we)
        code_q <= loc_wdata[3:0];
    end
  end

  assign image      = {bist_en, start_q, 2'b00, code_q};
  assign host_rdata = image;
  assign loc_rdata  = image;
  assign loc_irq    = start_q && bist_en;

endmodule

module bist_ctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bist_en,
  input logic       host_we,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       loc_we,
  input logic [7:0] loc_wdata,
  input logic [7:0] loc_rdata,
  input logic       loc_irq
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (host_rdata[6:0] == 7'h00 && !loc_irq));

  // R2
  cap_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[7] == bist_en && loc_rdata[7] == bist_en);

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[5:4] == 2'b00 && loc_rdata[5:4] == 2'b00);

  // R4
  host_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_wdata[6] |=> host_rdata[6]);

  // R5
  host_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && !loc_we |=> $stable(host_rdata[3:0]));

  // R6
  loc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_we && !loc_wdata[6] && !(host_we && host_wdata[6]) |=> !loc_rdata[6]);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_irq == (loc_rdata[6] && bist_en));

endmodule

bind bist_ctl_reg bist_ctl_reg_chk u_chk (.*);

// File: tb/test_bist_ctl_reg.sv
module test_bist_ctl_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bist_en = 1'b0;
  logic       host_we = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       loc_we = 1'b0;
  logic [7:0] loc_wdata = 8'h00;
  logic [7:0] loc_rdata;
  logic       loc_irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bist_ctl_reg i_bist_ctl_reg (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; host_we = 1'b0; loc_we = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic host_wr(input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic loc_wr(input logic [7:0] d);
    @(negedge clk);
    loc_we = 1'b1; loc_wdata = d;
    @(negedge clk);
    loc_we = 1'b0;
  endtask

  task automatic t_reset();
    bist_en = 1'b0;
    do_reset();
    chk("R1 host", host_rdata, 8'h00);
    chk("R1 loc", loc_rdata, 8'h00);
    chk("R1 irq", {7'd0, loc_irq}, 8'h00);
  endtask

  task automatic t_capability();
    do_reset();
    bist_en = 1'b1;
    #1;
    chk("R2 host en", host_rdata, 8'h80);
    chk("R2 loc en", loc_rdata, 8'h80);
    host_wr(8'h00);
    chk("R2 host wr", host_rdata, 8'h80);
    loc_wr(8'h00);
    chk("R2 loc wr", loc_rdata, 8'h80);
    bist_en = 1'b0;
    host_wr(8'h80);
    chk("R2 en low", host_rdata, 8'h00);
  endtask

  task automatic t_reserved();
    bist_en = 1'b0;
    do_reset();
    loc_wr(8'h35);
    chk("R3 loc wr", loc_rdata, 8'h05);
    host_wr(8'h30);
    chk("R3 host wr", host_rdata, 8'h05);
  endtask

  task automatic t_host_set();
    bist_en = 1'b0;
    do_reset();
    host_wr(8'h4A);
    chk("R4 set / R5 code", host_rdata, 8'h40);
    chk("R7 no irq en low", {7'd0, loc_irq}, 8'h00);
    host_wr(8'h00);
    chk("R4 no clear", host_rdata, 8'h40);
    bist_en = 1'b1;
    #1;
    chk("R7 irq on en", {7'd0, loc_irq}, 8'h01);
    chk("R7 read", loc_rdata, 8'hC0);
  endtask

  task automatic t_local();
    bist_en = 1'b1;
    do_reset();
    host_wr(8'h40);
    chk("R7 irq set", {7'd0, loc_irq}, 8'h01);
    loc_wr(8'h43);
    chk("R6 keep start", loc_rdata, 8'hC3);
    chk("R6 irq kept", {7'd0, loc_irq}, 8'h01);
    loc_wr(8'h07);
    chk("R9 loc done", loc_rdata, 8'h87);
    chk("R9 host done", host_rdata, 8'h87);
    chk("R9 irq low", {7'd0, loc_irq}, 8'h00);
    host_wr(8'h05);
    chk("R5 host code", host_rdata, 8'h87);
  endtask

  task automatic t_race();
    bist_en = 1'b1;
    do_reset();
    @(negedge clk);
    host_we = 1'b1; host_wdata = 8'h40;
    loc_we = 1'b1;  loc_wdata = 8'h02;
    @(negedge clk);
    host_we = 1'b0; loc_we = 1'b0;
    chk("R8 race", host_rdata, 8'hC2);
    chk("R8 irq", {7'd0, loc_irq}, 8'h01);
    do_reset();
    chk("R1 mid reset", host_rdata, 8'h80);
    chk("R1 mid irq", {7'd0, loc_irq}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_capability();
    t_reserved();
    t_host_set();
    t_local();
    t_race();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule